// File: doc/BRIEF.md
# Interleaved Spare-Row Steering

This block steers row accesses of a 128-word by 32-bit memory towards one of two spare rows when the addressed row has been marked as failing. The rows form four 32-row segments. Each spare serves two segments that are not next to each other: spare 1 serves rows 0–31 and 64–95, spare 0 serves rows 32–63 and 96–127. Because of this, row address bit 5 alone decides which spare may serve an access. Each spare replaces one whole row, all 32 data bits of it.

Each spare holds an enable bit and a 7-bit failing-row address. Both are loaded through a small write port. On each valid access the block compares the row with both spares, taking coverage into account. One cycle later it raises exactly one select: the normal wordline enable or one spare select. A spare that was loaded with an address outside its coverage never substitutes, and it raises a per-spare error flag.

Top module: `row_spare_steer`

## Requirements
- R1: While reset is asserted and right after it, both spares are disabled, `norm_en`, `spare_sel`, `row_q` and `cfg_bad` are all zero, and no access is redirected until a spare is programmed.
- R2: When spare 1 is enabled, the access row equals its stored address and row bit 5 is 0, then `spare_sel` is 2'b10 and `norm_en` is 0 in the cycle after the access.
- R3: When spare 0 is enabled, the access row equals its stored address and row bit 5 is 1, then `spare_sel` is 2'b01 and `norm_en` is 0 in the cycle after the access.
- R4: A spare whose stored address lies outside its coverage (bit 5 = 1 for spare 1, bit 5 = 0 for spare 0) never substitutes. An access to that stored row goes to the normal row.
- R5: `cfg_bad[k]` is 1 exactly when spare k is enabled and its stored address lies outside its coverage. It reflects a write from the edge that performs the write onwards.
- R6: At most one of `norm_en`, `spare_sel[1]` and `spare_sel[0]` is high in any cycle. On a substitution, `norm_en` is low.
- R7: A valid access produces its result one clock after it is presented. `row_q` returns the access row, and exactly one select is high. A cycle without `acc_valid` yields all selects low and `row_q` zero.
- R8: A disabled spare never substitutes, whatever address it stores.
- R9: A write (`cfg_we`, `cfg_idx` picks the spare, `cfg_en`, `cfg_row`) replaces that spare's whole entry. An access presented in the same cycle as the write still uses the previous entry. Accesses in later cycles use the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a repair entry |
| cfg_idx | input | 1 | Spare written: 0 or 1 |
| cfg_en | input | 1 | Enable value written |
| cfg_row | input | 7 | Failing-row address written |
| acc_valid | input | 1 | Access present this cycle |
| acc_row | input | 7 | Row address of the access |
| norm_en | output | 1 | Drive the normal wordline (registered) |
| spare_sel | output | 2 | Spare wordline selects, bit k = spare k (registered) |
| row_q | output | 7 | Registered access row for the array decoder |
| cfg_bad | output | 2 | Per-spare flag for an out-of-coverage entry |

## Verification
The wordline selects and `row_q` are due at the first rising edge after an access is driven. `cfg_bad` follows from the edge that performs a write. The driver task drives each cycle on the falling edge and queues the expected selects, row and flags. The monitor pops one entry a little after each rising edge, so every comparison falls in the cycle in which the result becomes valid. All 128 rows are swept under each legal, illegal, disabled and mixed programming. A write paired with an access in the same cycle checks that the old entry still governs that access.

// File: rtl/row_spare_steer.sv
module row_spare_steer #(
  parameter int ROW_W   = 7,
  parameter int SEG_BIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_idx,
  input  logic             cfg_en,
  input  logic [ROW_W-1:0] cfg_row,
  input  logic             acc_valid,
  input  logic [ROW_W-1:0] acc_row,
  output logic             norm_en,
  output logic [1:0]       spare_sel,
  output logic [ROW_W-1:0] row_q,
  output logic [1:0]       cfg_bad
);
  localparam int NSPARE = 2;

  logic [NSPARE-1:0] hit;

  for (genvar k = 0; k < NSPARE; k++) begin : g_sp
    localparam logic DOM = (k == 0);
    logic             en;
    logic [ROW_W-1:0] fail;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        en   <= 1'b0;
        fail <= '0;
      end else if (cfg_we && (cfg_idx == 1'(k))) begin
        en   <= cfg_en;
        fail <= cfg_row;
      end

    assign cfg_bad[k] = en && (fail[SEG_BIT] != DOM);
    assign hit[k]     = en && !cfg_bad[k] && (acc_row[SEG_BIT] == DOM) && (acc_row == fail);

    AST_BAD_NO_SUB: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bad[k] && acc_valid) |=> !spare_sel[k]); // R4
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      norm_en   <= 1'b0;
      spare_sel <= '0;
      row_q     <= '0;
    end else begin
      norm_en   <= acc_valid && !(|hit);
      spare_sel <= acc_valid ? hit : '0;
      row_q     <= acc_valid ? acc_row : '0;
    end

  AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({norm_en, spare_sel}) <= 1); // R6
  AST_SP1_DOMAIN: assert property (@(posedge clk) disable iff (!rst_n)
    spare_sel[1] |-> !row_q[SEG_BIT]); // R2
  AST_SP0_DOMAIN: assert property (@(posedge clk) disable iff (!rst_n)
    spare_sel[0] |-> row_q[SEG_BIT]); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!norm_en && spare_sel == 2'b00)); // R7
  AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> ($countones({norm_en, spare_sel}) == 1)); // R7
endmodule

// File: tb/sim_row_spare_steer.sv
module sim_row_spare_steer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_idx = 1'b0, cfg_en = 1'b0;
  logic [6:0] cfg_row = '0, acc_row = '0;
  logic acc_valid = 1'b0;
  logic norm_en;
  logic [1:0] spare_sel, cfg_bad;
  logic [6:0] row_q;

  always #4 clk = ~clk;

  row_spare_steer u0 (.clk, .rst_n, .cfg_we, .cfg_idx, .cfg_en, .cfg_row,
                      .acc_valid, .acc_row, .norm_en, .spare_sel, .row_q, .cfg_bad);

  typedef struct { logic norm; logic [1:0] sel; logic [6:0] row; logic [1:0] bad; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  logic m_en[2];
  logic [6:0] m_fail[2];
  bit done = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_hit(logic [6:0] r);
    exp_hit[1] = m_en[1] && !m_fail[1][5] && !r[5] && r == m_fail[1];
    exp_hit[0] = m_en[0] && m_fail[0][5] && r[5] && r == m_fail[0];
  endfunction

  function automatic logic [1:0] exp_bad();
    exp_bad = {m_en[1] && m_fail[1][5], m_en[0] && !m_fail[0][5]};
  endfunction

  task automatic step(logic v, logic [6:0] r, logic we, logic idx, logic en, logic [6:0] fr, string tag);
    item_t it;
    logic [1:0] h;
    @(negedge clk);
    acc_valid = v; acc_row = r;
    cfg_we = we; cfg_idx = idx; cfg_en = en; cfg_row = fr;
    h = exp_hit(r);
    if (we) begin m_en[idx] = en; m_fail[idx] = fr; end
    it.norm = v && (h == 2'b00);
    it.sel  = v ? h : 2'b00;
    it.row  = v ? r : 7'd0;
    it.bad  = exp_bad();
    it.tag  = (h[1] && v) ? "R2" : (h[0] && v) ? "R3" : tag;
    q.push_back(it);
  endtask

  task automatic prog(logic idx, logic en, logic [6:0] fr);
    step(1'b0, 7'd0, 1'b1, idx, en, fr, "R9");
  endtask

  task automatic sweep(string tag);
    for (int r = 0; r < 128; r++) step(1'b1, 7'(r), 1'b0, 1'b0, 1'b0, 7'd0, tag);
    step(1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 7'd0, "R7");
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk({it.tag, " norm_en"}, {7'd0, norm_en}, {7'd0, it.norm});
      chk({it.tag, " spare_sel"}, {6'd0, spare_sel}, {6'd0, it.sel});
      chk({it.tag, " row_q R7"}, {1'b0, row_q}, {1'b0, it.row});
      chk("R5 cfg_bad", {6'd0, cfg_bad}, {6'd0, it.bad});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_en[0] = 0; m_en[1] = 0; m_fail[0] = 0; m_fail[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset selects", {5'd0, norm_en, spare_sel}, 8'd0);
    chk("R1 reset flags", {1'b0, row_q}, 8'd0);
    chk("R1 reset bad", {6'd0, cfg_bad}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    sweep("R1");
    prog(1'b1, 1'b1, 7'd70);  prog(1'b0, 1'b1, 7'd40);  sweep("R7");
    prog(1'b1, 1'b1, 7'd0);   prog(1'b0, 1'b1, 7'd127); sweep("R6");
    prog(1'b1, 1'b1, 7'd100); prog(1'b0, 1'b1, 7'd10);  sweep("R4");
    prog(1'b1, 1'b1, 7'd31);  prog(1'b0, 1'b1, 7'd31);  sweep("R4");
    prog(1'b1, 1'b0, 7'd70);  prog(1'b0, 1'b0, 7'd40);  sweep("R8");
    prog(1'b1, 1'b0, 7'd100); sweep("R8");
    prog(1'b1, 1'b1, 7'd95);  prog(1'b0, 1'b1, 7'd32);  sweep("R9");
    step(1'b1, 7'd95, 1'b1, 1'b1, 1'b1, 7'd64, "R9");
    step(1'b1, 7'd95, 1'b0, 1'b0, 1'b0, 7'd0, "R9");
    step(1'b1, 7'd64, 1'b0, 1'b0, 1'b0, 7'd0, "R9");
    step(1'b1, 7'd32, 1'b1, 1'b0, 1'b0, 7'd32, "R9");
    step(1'b1, 7'd32, 1'b0, 1'b0, 1'b0, 7'd0, "R8");
    step(1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 7'd0, "R7");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule